// File: doc/BRIEF.md
# UDP Destination-Port Channel Demultiplexer

This block takes a byte-wide packet stream whose first byte is the first byte of a UDP header. It captures the 8-byte header, reads the destination port from it and looks that port up in a four-entry table that software fills at run time. The payload that follows the header is sent to the one output channel whose enabled entry holds that port. The header itself is never forwarded.

Each table entry has a 16-bit port number and an enable flag. Software writes and reads the entries through a small register port. Before it claims a channel, software can read the entry back to see whether that channel is already enabled. Packets that match no enabled entry are accepted at full rate and thrown away.

Each output channel has its own valid/ready stream with start and end markers. Backpressure on the chosen channel flows straight back to the input, so the block needs no payload buffer.

Top module: `udp_chan_demux`

## Requirements
- R1: After reset, `in_ready` is 1, no `out_valid` bit is set, and every table entry reads back as zero.
- R2: A register word carries the port number in bits 15:0 and the enable flag in bit 16. `reg_addr` values 0 to 3 select channels 0 to 3, and a read returns exactly what was last written to that address.
- R3: The destination port is formed from header byte 2 (most significant) and header byte 3 (least significant). The payload goes to the channel whose enabled entry equals that port. Bytes 0 and 1 have no influence on the routing.
- R4: Header bytes never appear on any output. The first payload byte is marked with `out_sop`, and the last payload byte carries `out_eop`, which mirrors the input end marker.
- R5: After the eighth header byte is accepted, `in_ready` stays low for exactly one cycle while the routing decision is made.
- R6: A packet whose port matches no enabled entry produces no output. A packet that matches only a disabled entry is treated the same way. After the decision cycle, `in_ready` stays high until that packet's end byte has been accepted.
- R7: When several enabled entries hold the same port, the lowest-numbered channel receives the packet.
- R8: While the selected channel deasserts `out_ready`, `in_ready` is low. Every payload byte is delivered exactly once and in order.
- R9: A packet of 8 bytes or fewer produces no output, and the next packet is parsed normally.
- R10: The table is sampled when a packet's first byte is accepted. A register write made later in that packet affects only the packets that follow.
- R11: At most one `out_valid` bit is set in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Channel register index for both reads and writes |
| reg_wdata | input | 17 | Write data: bit 16 is the enable flag, bits 15:0 the port number |
| reg_rdata | output | 17 | Read data of the addressed entry, same layout as the write data |
| in_data | input | 8 | Input stream byte |
| in_valid | input | 1 | Input byte valid |
| in_sop | input | 1 | Input byte is the first byte of a packet |
| in_eop | input | 1 | Input byte is the last byte of a packet |
| in_ready | output | 1 | Block accepts the input byte this cycle |
| out_data | output | 32 | Payload byte of each channel; channel i uses bits 8i+7:8i |
| out_valid | output | 4 | Per-channel payload byte valid |
| out_sop | output | 4 | Per-channel first payload byte marker |
| out_eop | output | 4 | Per-channel last payload byte marker |
| out_ready | input | 4 | Per-channel sink ready |

## Verification
The assertions assume that every packet on the input starts with `in_sop` and ends with exactly one `in_eop`. They also assume that the source holds a byte steady until it is accepted, and that a sink does not depend on seeing `out_valid` before it raises `out_ready`. The bench drives bytes only through a single task that sets the start marker on byte 0 and the end marker on the final byte, and that keeps each byte on the bus until a cycle where `in_ready` is high. The sinks' ready pattern comes from a free-running counter and is independent of the outputs. Register writes are made only between packets or after a packet's first byte, so the moment the table is sampled is always defined.

// File: rtl/udp_demux_pkg.sv
package udp_demux_pkg;
  localparam int PORT_W = 16;
  localparam int REG_W  = PORT_W + 1;

  typedef enum logic [1:0] {
    PH_HDR    = 2'd0,
    PH_DECIDE = 2'd1,
    PH_FWD    = 2'd2,
    PH_DROP   = 2'd3
  } phase_e;

  // Register word: enable flag above the port number.
  function automatic logic [REG_W-1:0] pack_entry(input logic en, input logic [PORT_W-1:0] port);
    return {en, port};
  endfunction

  // Destination port assembly: high byte then low byte.
  function automatic logic [PORT_W-1:0] join_port(input logic [7:0] hi, input logic [7:0] lo);
    return {hi, lo};
  endfunction
endpackage

// File: rtl/udp_chan_regs.sv
module udp_chan_regs
  import udp_demux_pkg::*;
#(
  parameter int NUM_CH = 4,
  localparam int ADDR_W = $clog2(NUM_CH)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          we,
  input  logic [ADDR_W-1:0]             addr,
  input  logic [REG_W-1:0]              wdata,
  output logic [REG_W-1:0]              rdata,
  output logic [NUM_CH-1:0]             cfg_en,
  output logic [NUM_CH-1:0][PORT_W-1:0] cfg_port
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_en   <= '0;
      cfg_port <= '0;
    end else if (we && (int'(addr) < NUM_CH)) begin
      cfg_en[addr]   <= wdata[PORT_W];
      cfg_port[addr] <= wdata[PORT_W-1:0];
    end
  end

  always_comb begin
    rdata = '0;
    if (int'(addr) < NUM_CH) rdata = pack_entry(cfg_en[addr], cfg_port[addr]);
  end
endmodule

// File: rtl/udp_port_match.sv
module udp_port_match
  import udp_demux_pkg::*;
#(
  parameter int NUM_CH = 4,
  localparam int SEL_W = $clog2(NUM_CH)
) (
  input  logic [NUM_CH-1:0]             en,
  input  logic [NUM_CH-1:0][PORT_W-1:0] tab,
  input  logic [PORT_W-1:0]             key,
  output logic                          hit,
  output logic [SEL_W-1:0]              sel
);
  // Walk from the top so the lowest matching index is left standing.
  always_comb begin
    hit = 1'b0;
    sel = '0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (en[i] && (tab[i] == key)) begin
        hit = 1'b1;
        sel = SEL_W'(i);
      end
    end
  end
endmodule

// File: rtl/udp_chan_demux.sv
module udp_chan_demux
  import udp_demux_pkg::*;
#(
  parameter int NUM_CH    = 4,
  parameter int HDR_BYTES = 8,
  parameter int PORT_BYTE = 2,
  localparam int ADDR_W = $clog2(NUM_CH),
  localparam int CNT_W  = $clog2(HDR_BYTES)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  reg_we,
  input  logic [ADDR_W-1:0]     reg_addr,
  input  logic [REG_W-1:0]      reg_wdata,
  output logic [REG_W-1:0]      reg_rdata,
  input  logic [7:0]            in_data,
  input  logic                  in_valid,
  input  logic                  in_sop,
  input  logic                  in_eop,
  output logic                  in_ready,
  output logic [NUM_CH*8-1:0]   out_data,
  output logic [NUM_CH-1:0]     out_valid,
  output logic [NUM_CH-1:0]     out_sop,
  output logic [NUM_CH-1:0]     out_eop,
  input  logic [NUM_CH-1:0]     out_ready
);
  logic [NUM_CH-1:0]             cfg_en, snap_en;
  logic [NUM_CH-1:0][PORT_W-1:0] cfg_port, snap_port;
  logic [7:0]                    port_hi;
  logic [PORT_W-1:0]             dport_q;
  logic [CNT_W-1:0]              hdr_cnt, hdr_idx;
  logic [ADDR_W-1:0]             sel_q, decide_sel;
  logic                          first_q, decide_hit;
  phase_e                        phase;

  // Named events for the checker.
  logic in_fire, hdr_phase, decide_phase, fwd_phase, drop_phase, hdr_last;

  udp_chan_regs #(.NUM_CH(NUM_CH)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .rdata(reg_rdata), .cfg_en(cfg_en), .cfg_port(cfg_port)
  );

  udp_port_match #(.NUM_CH(NUM_CH)) u_match (
    .en(snap_en), .tab(snap_port), .key(dport_q), .hit(decide_hit), .sel(decide_sel)
  );

  assign hdr_phase    = (phase == PH_HDR);
  assign decide_phase = (phase == PH_DECIDE);
  assign fwd_phase    = (phase == PH_FWD);
  assign drop_phase   = (phase == PH_DROP);
  assign in_fire      = in_valid && in_ready;
  assign hdr_idx      = in_sop ? '0 : hdr_cnt;
  assign hdr_last     = (int'(hdr_idx) == HDR_BYTES - 1);

  always_comb begin
    unique case (phase)
      PH_HDR:    in_ready = 1'b1;
      PH_DECIDE: in_ready = 1'b0;
      PH_FWD:    in_ready = out_ready[sel_q];
      default:   in_ready = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= PH_HDR;
      hdr_cnt   <= '0;
      port_hi   <= '0;
      dport_q   <= '0;
      snap_en   <= '0;
      snap_port <= '0;
      sel_q     <= '0;
      first_q   <= 1'b0;
    end else begin
      unique case (phase)
        PH_HDR: if (in_fire) begin
          if (hdr_idx == '0) begin
            snap_en   <= cfg_en;
            snap_port <= cfg_port;
          end
          if (int'(hdr_idx) == PORT_BYTE)     port_hi <= in_data;
          if (int'(hdr_idx) == PORT_BYTE + 1) dport_q <= join_port(port_hi, in_data);
          if (in_eop) begin
            hdr_cnt <= '0;
          end else if (hdr_last) begin
            hdr_cnt <= '0;
            phase   <= PH_DECIDE;
          end else begin
            hdr_cnt <= hdr_idx + 1'b1;
          end
        end
        PH_DECIDE: begin
          sel_q   <= decide_sel;
          first_q <= 1'b1;
          phase   <= decide_hit ? PH_FWD : PH_DROP;
        end
        PH_FWD: if (in_fire) begin
          first_q <= 1'b0;
          if (in_eop) phase <= PH_HDR;
        end
        default: if (in_fire && in_eop) phase <= PH_HDR;
      endcase
    end
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : g_out
    logic chan_on;
    assign chan_on              = fwd_phase && (sel_q == ADDR_W'(g)) && in_valid;
    assign out_valid[g]         = chan_on;
    assign out_data[g*8 +: 8]   = in_data;
    assign out_sop[g]           = chan_on && first_q;
    assign out_eop[g]           = chan_on && in_eop;
  end
endmodule

// File: rtl/udp_chan_demux_chk.sv
module udp_chan_demux_chk
  import udp_demux_pkg::*;
#(
  parameter int NUM_CH = 4,
  localparam int ADDR_W = $clog2(NUM_CH)
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          in_ready,
  input logic                          in_eop,
  input logic                          in_fire,
  input logic [NUM_CH-1:0]             out_valid,
  input logic [NUM_CH-1:0]             out_ready,
  input logic                          hdr_phase,
  input logic                          decide_phase,
  input logic                          fwd_phase,
  input logic                          drop_phase,
  input logic                          decide_hit,
  input logic [ADDR_W-1:0]             decide_sel,
  input logic [NUM_CH-1:0]             snap_en,
  input logic [NUM_CH-1:0][PORT_W-1:0] snap_port,
  input logic [PORT_W-1:0]             dport_q
);
  logic lower_hit;
  always_comb begin
    lower_hit = 1'b0;
    for (int i = 0; i < NUM_CH; i++)
      if ((i < int'(decide_sel)) && snap_en[i] && (snap_port[i] == dport_q)) lower_hit = 1'b1;
  end

  p_decide_stall_r5: assert property (@(posedge clk) disable iff (!rst_n)
    decide_phase |-> !in_ready);
  p_decide_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    decide_phase |=> !decide_phase);
  p_no_header_out_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (hdr_phase || decide_phase) |-> (out_valid == '0));
  p_one_channel_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(out_valid));
  p_hit_matches_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (decide_phase && decide_hit) |-> (snap_en[decide_sel] && (snap_port[decide_sel] == dport_q)));
  p_lowest_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (decide_phase && decide_hit) |-> !lower_hit);
  p_drop_silent_r6: assert property (@(posedge clk) disable iff (!rst_n)
    drop_phase |-> (in_ready && (out_valid == '0)));
  p_end_returns_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((fwd_phase || drop_phase) && in_fire && in_eop) |=> hdr_phase);

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
    p_beat_consumes_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid[g] && out_ready[g]) |-> in_fire);
    p_stall_back_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid[g] && !out_ready[g]) |-> !in_ready);
  end
endmodule

bind udp_chan_demux udp_chan_demux_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .in_eop(in_eop), .in_fire(in_fire),
  .out_valid(out_valid), .out_ready(out_ready), .hdr_phase(hdr_phase),
  .decide_phase(decide_phase), .fwd_phase(fwd_phase), .drop_phase(drop_phase),
  .decide_hit(decide_hit), .decide_sel(decide_sel), .snap_en(snap_en),
  .snap_port(snap_port), .dport_q(dport_q)
);

// File: tb/test_udp_chan_demux.sv
module test_udp_chan_demux;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [1:0] reg_addr = '0;
  logic [16:0] reg_wdata = '0, reg_rdata;
  logic [7:0] in_data = '0;
  logic in_valid = 1'b0, in_sop = 1'b0, in_eop = 1'b0, in_ready;
  logic [NCH*8-1:0] out_data;
  logic [NCH-1:0] out_valid, out_sop, out_eop;
  logic [NCH-1:0] out_ready = '1;

  int checks = 0, errors = 0;
  logic [7:0] pkt [0:63];
  int stall_at [0:63];
  logic [7:0] got_d [NCH][0:63];
  logic got_s [NCH][0:63];
  logic got_e [NCH][0:63];
  int got_n [NCH];
  int multi_valid = 0;
  bit bp_mode = 1'b0;
  int cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  udp_chan_demux i_udp_chan_demux (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .in_data(in_data), .in_valid(in_valid), .in_sop(in_sop),
    .in_eop(in_eop), .in_ready(in_ready), .out_data(out_data), .out_valid(out_valid),
    .out_sop(out_sop), .out_eop(out_eop), .out_ready(out_ready)
  );

  // Sink ready pattern, independent of the outputs.
  always @(posedge clk) begin
    #1;
    cyc++;
    out_ready = bp_mode ? {NCH{(cyc % 3) != 1}} : '1;
  end

  // Beat monitor, sampled mid-cycle.
  always @(negedge clk) begin
    if ($countones(out_valid) > 1) multi_valid++;
    for (int c = 0; c < NCH; c++) begin
      if (out_valid[c] && out_ready[c] && got_n[c] < 64) begin
        got_d[c][got_n[c]] = out_data[c*8 +: 8];
        got_s[c][got_n[c]] = out_sop[c];
        got_e[c][got_n[c]] = out_eop[c];
        got_n[c]++;
      end
    end
  end

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic clear_got();
    for (int c = 0; c < NCH; c++) got_n[c] = 0;
  endtask

  task automatic reg_write(input int ch, input logic en, input logic [15:0] port);
    @(posedge clk); #1;
    reg_we = 1'b1; reg_addr = 2'(ch); reg_wdata = {en, port};
    @(posedge clk); #1;
    reg_we = 1'b0;
  endtask

  task automatic reg_read(input int ch, output logic [16:0] val);
    @(posedge clk); #1;
    reg_addr = 2'(ch);
    @(negedge clk);
    val = reg_rdata;
  endtask

  // Header: src port, dst port, length, checksum; then payload seed+k.
  task automatic build(input logic [15:0] src, input logic [15:0] dst, input int plen, input int seed);
    pkt[0] = src[15:8]; pkt[1] = src[7:0];
    pkt[2] = dst[15:8]; pkt[3] = dst[7:0];
    pkt[4] = 8'(((plen + 8) >> 8)); pkt[5] = 8'(plen + 8);
    pkt[6] = 8'h00; pkt[7] = 8'h00;
    for (int k = 0; k < plen; k++) pkt[8+k] = 8'(seed + k * 7);
  endtask

  task automatic send_frame(input int n);
    for (int k = 0; k < n; k++) begin
      @(posedge clk); #1;
      in_valid = 1'b1; in_data = pkt[k]; in_sop = (k == 0); in_eop = (k == n - 1);
      stall_at[k] = 0;
      @(negedge clk);
      while (!in_ready) begin
        stall_at[k]++;
        @(negedge clk);
      end
    end
    @(posedge clk); #1;
    in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
    repeat (2) @(posedge clk);
  endtask

  task automatic expect_on(input int ch, input int plen, input string req);
    bit data_ok = 1'b1, mark_ok = 1'b1;
    check(got_n[ch] == plen, req, $sformatf("beats on ch%0d", ch), got_n[ch], plen);
    for (int c = 0; c < NCH; c++)
      if (c != ch) check(got_n[c] == 0, req, $sformatf("stray beats on ch%0d", c), got_n[c], 0);
    if (got_n[ch] == plen) begin
      for (int k = 0; k < plen; k++) begin
        if (got_d[ch][k] != pkt[8+k]) data_ok = 1'b0;
        if (got_s[ch][k] != (k == 0) || got_e[ch][k] != (k == plen - 1)) mark_ok = 1'b0;
      end
      check(data_ok, req, "payload bytes match", int'(data_ok), 1);
      check(mark_ok, "R4", "sop/eop markers", int'(mark_ok), 1);
    end
  endtask

  task automatic expect_none(input string req);
    for (int c = 0; c < NCH; c++)
      check(got_n[c] == 0, req, $sformatf("beats on ch%0d", c), got_n[c], 0);
  endtask

  task automatic t_reset();
    logic [16:0] v;
    check(in_ready == 1'b1, "R1", "in_ready after reset", int'(in_ready), 1);
    check(out_valid == '0, "R1", "out_valid after reset", int'(out_valid), 0);
    for (int c = 0; c < NCH; c++) begin
      reg_read(c, v);
      check(v == '0, "R1", $sformatf("entry %0d after reset", c), int'(v), 0);
    end
  endtask

  task automatic t_regs();
    logic [16:0] v;
    reg_write(0, 1'b1, 16'h1234);
    reg_write(1, 1'b0, 16'hABCD);
    reg_write(3, 1'b1, 16'h00FF);
    reg_read(0, v); check(v == 17'h11234, "R2", "entry 0 readback", int'(v), 'h11234);
    reg_read(1, v); check(v == 17'h0ABCD, "R2", "entry 1 readback", int'(v), 'h0ABCD);
    reg_read(2, v); check(v == 17'h00000, "R2", "entry 2 untouched", int'(v), 0);
    reg_read(3, v); check(v == 17'h100FF, "R2", "entry 3 readback", int'(v), 'h100FF);
  endtask

  task automatic setup_table();
    reg_write(0, 1'b1, 16'd1000);
    reg_write(1, 1'b1, 16'd2000);
    reg_write(2, 1'b1, 16'd3000);
    reg_write(3, 1'b1, 16'd4000);
  endtask

  task automatic t_route();
    // Source port equals entry 3; only the destination may steer (R3).
    build(16'd4000, 16'd3000, 5, 8'h40);
    clear_got(); send_frame(13);
    expect_on(2, 5, "R3");
    check(stall_at[8] == 1, "R5", "decision stall cycles", stall_at[8], 1);
    build(16'd1, 16'd1000, 9, 8'h11);
    clear_got(); send_frame(17);
    expect_on(0, 9, "R3");
  endtask

  task automatic t_drop();
    int total;
    build(16'd1000, 16'd5555, 6, 8'h20);
    clear_got(); send_frame(14);
    expect_none("R6");
    total = 0;
    for (int k = 0; k < 14; k++) total += stall_at[k];
    check(total == 1, "R6", "stalls on dropped packet", total, 1);
    reg_write(1, 1'b0, 16'd2000);
    build(16'd9, 16'd2000, 4, 8'h30);
    clear_got(); send_frame(12);
    expect_none("R6");
    reg_write(1, 1'b1, 16'd2000);
  endtask

  task automatic t_dup();
    reg_write(1, 1'b1, 16'd7000);
    reg_write(3, 1'b1, 16'd7000);
    build(16'd2, 16'd7000, 3, 8'h50);
    clear_got(); send_frame(11);
    expect_on(1, 3, "R7");
    reg_write(1, 1'b1, 16'd2000);
    reg_write(3, 1'b1, 16'd4000);
  endtask

  task automatic t_backpressure();
    int total;
    bp_mode = 1'b1;
    build(16'd3, 16'd4000, 20, 8'h60);
    clear_got(); send_frame(28);
    expect_on(3, 20, "R8");
    total = 0;
    for (int k = 9; k < 28; k++) total += stall_at[k];
    check(total > 0, "R8", "input stalled by sink", total, 1);
    bp_mode = 1'b0;
  endtask

  task automatic t_short();
    build(16'd4, 16'd1000, 0, 0);
    clear_got(); send_frame(8);
    expect_none("R9");
    clear_got(); send_frame(3);
    expect_none("R9");
    build(16'd4, 16'd1000, 2, 8'h70);
    clear_got(); send_frame(10);
    expect_on(0, 2, "R9");
  endtask

  task automatic t_midwrite();
    build(16'd5, 16'd1000, 6, 8'h80);
    clear_got();
    fork
      send_frame(14);
      begin
        repeat (4) @(posedge clk);
        reg_write(0, 1'b1, 16'h2222);
      end
    join
    expect_on(0, 6, "R10");
    build(16'd5, 16'd1000, 4, 8'h90);
    clear_got(); send_frame(12);
    expect_none("R10");
    build(16'd5, 16'h2222, 4, 8'hA0);
    clear_got(); send_frame(12);
    expect_on(0, 4, "R10");
  endtask

  initial begin
    for (int c = 0; c < NCH; c++) got_n[c] = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regs();
    setup_table();
    t_route();
    t_drop();
    t_dup();
    t_backpressure();
    t_short();
    t_midwrite();
    check(multi_valid == 0, "R11", "cycles with several out_valid", multi_valid, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule